// File: doc/BRIEF.md
# Key Scan Debounce and Interrupt Unit

This unit sits behind the shared segment/key pads of a small LCD driver. Once per display frame a neighbouring timing block raises a one-cycle scan strobe while the key inputs are valid. The unit debounces each key over successive scans and records every newly accepted key in a set of byte-wide key registers. It also raises an interrupt flag and drives a pin level whose polarity can be configured.

Software reads the three key registers in one transaction. When that read completes, the bus side sends a read-done pulse, and the pulse clears both the key data and the flag. Key data is not queued: presses that are not read pile up as a bitwise OR, and press order is lost.

In standby the unit holds all key state cleared and ignores scan strobes. While in standby it reports any press on a scannable key as a wake request. The scanned key set depends on the display mode. In 20-key mode (`eightCom`=0) keys 0..19 are scanned. In 16-key mode (`eightCom`=1) keys 0..15 are scanned. In either mode, the key whose pad carries the interrupt output is dropped from the scan while that output is enabled.

Top module: `keyscan_top`

## Requirements
- R1: A key is accepted only on a scan strobe where it is sampled pressed and was also sampled pressed on the previous scan strobe. A single-scan press leaves `keyRegs` at zero.
- R2: A key that stays held is accepted once only. It must be sampled released on some scan before it can be accepted again.
- R3: Accepted keys are ORed into the key registers. Earlier unread keys stay set when later keys are accepted.
- R4: `keyRegs` byte 0 holds keys 7..0 (key 0 at bit 0). Byte 1 holds keys 15..8. Byte 2 holds keys 19..16 in bits 3..0, and bits 7..4 of byte 2 always read 0.
- R5: `flagReg` bit 0 is set on the cycle after any key is accepted, and bits 7..1 are 0. A `readDone` pulse with no accept in the same cycle clears the key data and the flag to 0 on the next cycle.
- R6: `intPinOe` equals `intEnable`. When the flag is set, `intPinLevel` is 0 if `intActHigh`=0 and 1 if `intActHigh`=1. When the flag is clear, `intPinLevel` takes the opposite level.
- R7: While `standby`=1, key data, the flag and the debounce history are held at 0, and scan strobes are ignored. After standby ends, a key needs two fresh pressed scans before it is accepted.
- R8: In 20-key mode, key 19 is not scanned while `intEnable`=1. In 16-key mode, keys 16..19 are never scanned, and key 15 is not scanned while `intEnable`=1. Unscanned keys are neither accepted nor able to cause a wake request.
- R9: If an accept and a `readDone` pulse fall in the same cycle, the key data afterwards holds only the newly accepted keys, and the flag stays set.
- R10: `wakeReq` is 1 on the cycle after any cycle in which `standby`=1 and a scannable key input is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scanStrobe | input | 1 | One-cycle pulse per frame; `keyIn` is valid on this cycle |
| keyIn | input | 20 | Raw key samples, 1 = pressed |
| eightCom | input | 1 | 0 = 20-key mode, 1 = 16-key mode |
| intEnable | input | 1 | 1 = interrupt output owns its shared pad |
| intActHigh | input | 1 | Interrupt pin polarity, 1 = active-high |
| standby | input | 1 | Standby level |
| readDone | input | 1 | One-cycle pulse: full key register read finished |
| keyRegs | output | 24 | Key registers, byte n = register n |
| flagReg | output | 8 | Flag register, bit 0 = interrupt flag |
| intPinOe | output | 1 | Interrupt pad output enable |
| intPinLevel | output | 1 | Interrupt pad level |
| wakeReq | output | 1 | Wake request during standby |

## Verification
Suppose a debounce cell's history or reported bit is wrong. The fault shows at `keyRegs` one scan strobe early or late: either a key appears after a single scan, or a held key reappears after a read-clear. In both cases the error is visible on the cycle after the strobe. A flag that drifts from the key data shows at once on `intPinLevel` under either polarity. History that survives standby shows as an accept on the first scan after wake-up. The directed scenarios place a check right after each strobe, so each of these faults is caught within the scan that exposes it.

// File: rtl/keyscan_pkg.sv
`timescale 1ns/1ps
package keyscan_pkg;
  // Strobes issued by the control half to the key datapath
  typedef struct packed {
    logic sampleEn;   // accept a scan sample this cycle
    logic readClear;  // wipe accumulated key data
    logic holdOff;    // standby: hold everything cleared
  } scanCtrl_t;
endpackage

// File: rtl/keyscan_datapath.sv
`timescale 1ns/1ps
module keyscan_datapath
  import keyscan_pkg::*;
#(
  parameter int NUM_KEYS    = 20,
  parameter int NARROW_KEYS = 16,
  localparam int NUM_BYTES  = (NUM_KEYS + 7) / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  scanCtrl_t              ctrl,
  input  logic [NUM_KEYS-1:0]    keyIn,
  input  logic                   eightCom,
  input  logic                   intEnable,
  output logic [8*NUM_BYTES-1:0] keyRegs,
  output logic                   acceptAny,
  output logic                   rawAny
);
  logic [NUM_KEYS-1:0] scanMask;
  logic [NUM_KEYS-1:0] sampleBits;
  logic [NUM_KEYS-1:0] prevSeen;
  logic [NUM_KEYS-1:0] reported;
  logic [NUM_KEYS-1:0] accept;
  logic [NUM_KEYS-1:0] keyData;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    localparam bit IN_NARROW     = (k < NARROW_KEYS);
    localparam bit IS_NARROW_INT = (k == NARROW_KEYS - 1);
    localparam bit IS_WIDE_INT   = (k == NUM_KEYS - 1);

    // R8: pad sharing decides which keys take part in the scan
    assign scanMask[k] = eightCom ? (IN_NARROW && !(intEnable && IS_NARROW_INT))
                                  : !(intEnable && IS_WIDE_INT);
    assign sampleBits[k] = keyIn[k] & scanMask[k];

    // R1/R2: pressed twice in a row and not yet reported
    assign accept[k] = ctrl.sampleEn & sampleBits[k] & prevSeen[k] & ~reported[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prevSeen[k] <= 1'b0;
        reported[k] <= 1'b0;
      end else if (ctrl.holdOff) begin
        prevSeen[k] <= 1'b0;
        reported[k] <= 1'b0;
      end else if (ctrl.sampleEn) begin
        prevSeen[k] <= sampleBits[k];
        reported[k] <= sampleBits[k] & (reported[k] | prevSeen[k]);
      end
    end
  end

  // R3/R9: accumulate, new accepts survive a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keyData <= '0;
    end else if (ctrl.holdOff) begin
      keyData <= '0;
    end else begin
      keyData <= (ctrl.readClear ? '0 : keyData) | accept;
    end
  end

  assign acceptAny = |accept;
  assign rawAny    = |sampleBits;

  // R4: zero-padded byte packing
  always_comb begin
    keyRegs = '0;
    keyRegs[NUM_KEYS-1:0] = keyData;
  end

  p_no_new_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.sampleEn |=> ((keyData & ~$past(keyData)) == '0));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.readClear && !acceptAny) |=> (keyData == '0));

  p_accept_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.readClear && acceptAny && !ctrl.holdOff) |=> (keyData != '0));

  p_standby_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.holdOff |=> (keyData == '0));
endmodule

// File: rtl/keyscan_ctrl.sv
`timescale 1ns/1ps
module keyscan_ctrl
  import keyscan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scanStrobe,
  input  logic      standby,
  input  logic      readDone,
  input  logic      acceptAny,
  input  logic      rawAny,
  input  logic      intEnable,
  input  logic      intActHigh,
  output scanCtrl_t ctrl,
  output logic      intFlag,
  output logic      intPinOe,
  output logic      intPinLevel,
  output logic      wakeReq
);
  always_comb begin
    ctrl.sampleEn  = scanStrobe & ~standby;
    ctrl.readClear = readDone & ~standby;
    ctrl.holdOff   = standby;
  end

  // R5/R9: accept wins over read-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              intFlag <= 1'b0;
    else if (standby)        intFlag <= 1'b0;
    else if (acceptAny)      intFlag <= 1'b1;
    else if (readDone)       intFlag <= 1'b0;
  end

  // R10: wake on any scannable key while in standby
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wakeReq <= 1'b0;
    else        wakeReq <= standby & rawAny;
  end

  // R6: polarity select
  assign intPinOe    = intEnable;
  assign intPinLevel = intActHigh ? intFlag : ~intFlag;

  p_flag_needs_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intFlag) |-> $past(acceptAny));

  p_standby_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !intFlag);

  p_wake_only_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wakeReq |-> $past(standby));
endmodule

// File: rtl/keyscan_top.sv
`timescale 1ns/1ps
module keyscan_top
  import keyscan_pkg::*;
#(
  parameter int NUM_KEYS    = 20,
  parameter int NARROW_KEYS = 16,
  localparam int NUM_BYTES  = (NUM_KEYS + 7) / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scanStrobe,
  input  logic [NUM_KEYS-1:0]    keyIn,
  input  logic                   eightCom,
  input  logic                   intEnable,
  input  logic                   intActHigh,
  input  logic                   standby,
  input  logic                   readDone,
  output logic [8*NUM_BYTES-1:0] keyRegs,
  output logic [7:0]             flagReg,
  output logic                   intPinOe,
  output logic                   intPinLevel,
  output logic                   wakeReq
);
  scanCtrl_t ctrl;
  logic acceptAny;
  logic rawAny;
  logic intFlag;

  keyscan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scanStrobe (scanStrobe),
    .standby    (standby),
    .readDone   (readDone),
    .acceptAny  (acceptAny),
    .rawAny     (rawAny),
    .intEnable  (intEnable),
    .intActHigh (intActHigh),
    .ctrl       (ctrl),
    .intFlag    (intFlag),
    .intPinOe   (intPinOe),
    .intPinLevel(intPinLevel),
    .wakeReq    (wakeReq)
  );

  keyscan_datapath #(
    .NUM_KEYS   (NUM_KEYS),
    .NARROW_KEYS(NARROW_KEYS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .keyIn     (keyIn),
    .eightCom  (eightCom),
    .intEnable (intEnable),
    .keyRegs   (keyRegs),
    .acceptAny (acceptAny),
    .rawAny    (rawAny)
  );

  assign flagReg = {7'b0, intFlag};
endmodule

// File: tb/tb_keyscan_top.sv
`timescale 1ns/1ps
module tb_keyscan_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scanStrobe = 1'b0;
  logic [19:0] keyIn = '0;
  logic        eightCom = 1'b0;
  logic        intEnable = 1'b1;
  logic        intActHigh = 1'b0;
  logic        standby = 1'b0;
  logic        readDone = 1'b0;
  logic [23:0] keyRegs;
  logic [7:0]  flagReg;
  logic        intPinOe;
  logic        intPinLevel;
  logic        wakeReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  keyscan_top dut (
    .clk(clk), .rst_n(rst_n), .scanStrobe(scanStrobe), .keyIn(keyIn),
    .eightCom(eightCom), .intEnable(intEnable), .intActHigh(intActHigh),
    .standby(standby), .readDone(readDone), .keyRegs(keyRegs),
    .flagReg(flagReg), .intPinOe(intPinOe), .intPinLevel(intPinLevel),
    .wakeReq(wakeReq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one scan strobe with the given keys; returns after the update edge
  task automatic scan(input logic [19:0] k);
    @(negedge clk);
    keyIn = k;
    scanStrobe = 1'b1;
    @(negedge clk);
    scanStrobe = 1'b0;
  endtask

  task automatic readClear();
    @(negedge clk);
    readDone = 1'b1;
    @(negedge clk);
    readDone = 1'b0;
  endtask

  task automatic t_reset();
    check("R4 reset keyRegs", keyRegs, 0);
    check("R5 reset flag", flagReg, 0);
    check("R6 reset pin oe", intPinOe, 1);
    check("R6 reset pin inactive low-pol", intPinLevel, 1);
    check("R10 reset wake", wakeReq, 0);
  endtask

  task automatic t_debounce();
    scan(20'h8); scan(20'h0);
    check("R1 single scan ignored", keyRegs, 0);
    check("R1 single scan no flag", flagReg, 0);
    scan(20'h8); scan(20'h8);
    check("R1 two scans accepted", keyRegs, 24'h000008);
    check("R5 flag set", flagReg, 8'h01);
    check("R6 active-low asserted", intPinLevel, 0);
  endtask

  task automatic t_hold();
    scan(20'h8);
    readClear();
    check("R5 read clears data", keyRegs, 0);
    check("R5 read clears flag", flagReg, 0);
    scan(20'h8); scan(20'h8);
    check("R2 held key not re-reported", keyRegs, 0);
    scan(20'h0); scan(20'h8); scan(20'h8);
    check("R2 re-press after release", keyRegs, 24'h000008);
    scan(20'h0);
    readClear();
  endtask

  task automatic t_accumulate();
    scan(20'h200); scan(20'h200);
    check("R4 key9 in byte1", keyRegs, 24'h000200);
    scan(20'h20000); scan(20'h20000);
    check("R3 accumulate key17", keyRegs, 24'h020200);
    scan(20'h1); scan(20'h1);
    check("R3 accumulate key0", keyRegs, 24'h020201);
    check("R4 byte2 upper nibble zero", keyRegs[23:20], 0);
    scan(20'h0);
    readClear();
    check("R5 clear after accumulate", keyRegs, 0);
  endtask

  task automatic t_masking();
    scan(20'h80000); scan(20'h80000);
    check("R8 wide int key19 unscanned", keyRegs, 0);
    scan(20'h0);
    eightCom = 1'b1;
    scan(20'h20000); scan(20'h20000);
    check("R8 narrow key17 unscanned", keyRegs, 0);
    scan(20'h8000); scan(20'h8000);
    check("R8 narrow int key15 unscanned", keyRegs, 0);
    scan(20'h4000); scan(20'h4000);
    check("R8 narrow key14 scanned", keyRegs, 24'h004000);
    scan(20'h0);
    intEnable = 1'b0;
    scan(20'h8000); scan(20'h8000);
    check("R8 key15 scanned without int", keyRegs, 24'h00C000);
    check("R6 oe follows enable", intPinOe, 0);
    scan(20'h0);
    readClear();
    eightCom = 1'b0;
    intEnable = 1'b1;
  endtask

  task automatic t_polarity();
    scan(20'h4); scan(20'h4);
    check("R6 active-low asserted", intPinLevel, 0);
    @(negedge clk); intActHigh = 1'b1; #1;
    check("R6 active-high asserted", intPinLevel, 1);
    scan(20'h0);
    readClear();
    check("R6 active-high idle", intPinLevel, 0);
    @(negedge clk); intActHigh = 1'b0; #1;
    check("R6 active-low idle", intPinLevel, 1);
  endtask

  task automatic t_collision();
    scan(20'h20); scan(20'h20);
    check("R9 setup data", keyRegs, 24'h000020);
    scan(20'h10);
    @(negedge clk);
    keyIn = 20'h10; scanStrobe = 1'b1; readDone = 1'b1;
    @(negedge clk);
    scanStrobe = 1'b0; readDone = 1'b0;
    check("R9 only new key kept", keyRegs, 24'h000010);
    check("R9 flag stays set", flagReg, 8'h01);
    scan(20'h0);
    readClear();
  endtask

  task automatic t_standby();
    scan(20'h40); scan(20'h40);
    @(negedge clk); keyIn = 20'h0; standby = 1'b1;
    @(negedge clk);
    check("R7 standby clears data", keyRegs, 0);
    check("R7 standby clears flag", flagReg, 0);
    check("R7 pin inactive in standby", intPinLevel, 1);
    check("R10 no wake without key", wakeReq, 0);
    scan(20'h40); scan(20'h40);
    check("R7 strobes ignored in standby", keyRegs, 0);
    check("R10 wake on key", wakeReq, 1);
    @(negedge clk); keyIn = 20'h80000;
    @(negedge clk);
    check("R8 masked key no wake", wakeReq, 0);
    @(negedge clk); keyIn = 20'h0; standby = 1'b0;
    @(negedge clk);
    check("R10 wake low after standby", wakeReq, 0);
    scan(20'h40);
    check("R7 history cleared by standby", keyRegs, 0);
    scan(20'h40);
    check("R7 accepted after two fresh scans", keyRegs, 24'h000040);
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_debounce();
    t_hold();
    t_accumulate();
    t_masking();
    t_polarity();
    t_collision();
    t_standby();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule